// File: doc/BRIEF.md
# MCU Reset and Start-up Sequencer

This block decides when a small 8-bit microcontroller core may run after power is applied, after a reset on the external pin, after a watchdog expiry, and when the core leaves its low-power halt mode. It holds the core during an oscillator settling period of 1024 system clocks. On a full system reset it then adds a short period for loading configuration options. When the core wakes from halt it adds a single dummy cycle instead.

A watchdog expiry while the core is halted causes a warm reset. This restarts only the program counter and stack pointer and leaves all other state as it was. Every other reset cause produces a cold reset. Two status flags, a time-out flag and a power-down flag, record what caused the last reset or wake-up. The core reads them to tell the causes apart. The external pin is synchronised and debounced before the sequencer acts on it.

Top module: `mcu_rst_seq`

## Requirements
- R1: Release of the power-up reset `rst_ni` leaves `cold_rst_o` and `core_hold_o` high for exactly 1024 + 16 = 1040 clock cycles, counting the cycle in which the release happens. After that both are low. The time-out flag `to_o` and the power-down flag `pdf_o` read 0/0.
- R2: A watchdog time-out pulse while the core runs (not halted) gives a cold reset with `core_hold_o` high for 1040 cycles after the sampling edge. `to_o` becomes 1 and `pdf_o` keeps its value.
- R3: A watchdog time-out while halted gives a warm reset. `warm_rst_o` is high during the 1024-cycle start-up delay and `cold_rst_o` stays low. `core_hold_o` is high for 1025 cycles: the delay plus one dummy cycle. The flags become 1/1.
- R4: A debounced pin reset while the core runs holds `cold_rst_o` and `core_hold_o` high while the pin is low. After release it applies the full start-up and option-load delay. `to_o`/`pdf_o` are unchanged.
- R5: A debounced pin reset while halted gives a cold reset, not a warm one, and sets the flags to 0/1.
- R6: `pin_rst_ni` passes through a two-stage synchroniser and must stay low for 4 consecutive synchronised clocks to take effect. A shorter low pulse causes no reset and leaves the flags unchanged.
- R7: A wake-up request while halted holds the core for 1024 start-up cycles plus one dummy cycle, with no option-load delay. `dummy_o` is high for exactly one cycle, the last held cycle. Neither reset output is raised and the flags are unchanged.
- R8: A rising edge of `halt_i` while the core runs enters halt and sets the flags to `to_o`=0, `pdf_o`=1. `core_hold_o` stays low.
- R9: A `wdt_clear_i` pulse while the core runs clears both flags to 0/0.
- R10: A wake-up request while the core runs (not halted) has no effect: `core_hold_o` and `dummy_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System oscillator clock |
| rst_ni | input | 1 | Power-up indication, active-low asynchronous |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous to the clock |
| wdt_timeout_i | input | 1 | Watchdog expiry pulse |
| wdt_clear_i | input | 1 | Watchdog-clear instruction executed |
| halt_i | input | 1 | Core is in halt mode (level) |
| wake_req_i | input | 1 | Wake-up request (interrupt or port change) |
| cold_rst_o | output | 1 | Full reset of core and peripherals |
| warm_rst_o | output | 1 | Reset of program counter and stack pointer only |
| core_hold_o | output | 1 | Core execution stalled |
| dummy_o | output | 1 | Dummy cycle after wake-up |
| to_o | output | 1 | Time-out flag |
| pdf_o | output | 1 | Power-down flag |

## Verification
The hardest cases to reach are the two resets that happen during halt: a watchdog expiry and a pin assertion, each with the core already halted. Each needs a chain of events. The bench first brings the core to run mode through the whole power-up delay. It then raises `halt_i` to enter halt, and only then applies the watchdog pulse or a pin low that lasts longer than the debounce window. The bench counts held cycles, dummy cycles and warm-reset cycles for each path. This tells the warm path apart from the cold path and from a plain wake-up.

// File: rtl/mcu_rst_pkg.sv
package mcu_rst_pkg;
  typedef enum logic [2:0] {
    ST_PIN   = 3'd0,
    ST_SST   = 3'd1,
    ST_OPT   = 3'd2,
    ST_RUN   = 3'd3,
    ST_HALT  = 3'd4,
    ST_WSST  = 3'd5,
    ST_DUMMY = 3'd6
  } rst_state_e;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic active_o
);
  localparam int DW = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DW-1:0]          deb_q;
  logic                   raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end

  assign raw = ~sync_q[SYNC_STAGES-1];

  // output follows raw only after DEB_CYCLES consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deb_q    <= '0;
      active_o <= 1'b0;
    end else if (raw == active_o) begin
      deb_q <= '0;
    end else if (deb_q == DW'(DEB_CYCLES - 1)) begin
      deb_q    <= '0;
      active_o <= raw;
    end else begin
      deb_q <= deb_q + 1'b1;
    end
  end

  a_r6_deb_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_o) |-> active_o == $past(raw));
endmodule

// File: rtl/rst_delay_cnt.sv
module rst_delay_cnt #(
  parameter bit POW2  = 1'b1,
  parameter int W     = 10,
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || done_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (POW2) begin : g_ovf
      // delay ends on the carry out of the W-bit counter
      logic [W:0] sum;
      assign sum    = {1'b0, cnt_q} + (W+1)'(1);
      assign done_o = run_i & sum[W];
    end else begin : g_cmp
      assign done_o = run_i & (cnt_q == W'(LIMIT - 1));

      a_r1_opt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> cnt_q < W'(LIMIT));
    end
  endgenerate

  a_r1_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import mcu_rst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_act_i,
  input  logic       wdt_to_i,
  input  logic       halt_i,
  input  logic       wake_i,
  input  logic       sst_done_i,
  input  logic       opt_done_i,
  output rst_state_e state_o,
  output logic       warm_o,
  output logic       ev_pin_halt_o,
  output logic       ev_wdt_run_o,
  output logic       ev_wdt_halt_o,
  output logic       ev_halt_o
);
  rst_state_e state_q, state_d;
  logic       halt_q, warm_q, warm_d, halt_rise;

  assign halt_rise = halt_i & ~halt_q;

  always_comb begin
    state_d       = state_q;
    warm_d        = warm_q;
    ev_pin_halt_o = 1'b0;
    ev_wdt_run_o  = 1'b0;
    ev_wdt_halt_o = 1'b0;
    ev_halt_o     = 1'b0;
    if (pin_act_i) begin
      state_d       = ST_PIN;
      warm_d        = 1'b0;
      ev_pin_halt_o = (state_q == ST_HALT);
    end else begin
      unique case (state_q)
        ST_PIN:  state_d = ST_SST;
        ST_SST:  if (sst_done_i) state_d = ST_OPT;
        ST_OPT:  if (opt_done_i) state_d = ST_RUN;
        ST_RUN: begin
          if (wdt_to_i) begin
            state_d      = ST_SST;
            ev_wdt_run_o = 1'b1;
          end else if (halt_rise) begin
            state_d   = ST_HALT;
            ev_halt_o = 1'b1;
          end
        end
        ST_HALT: begin
          if (wdt_to_i) begin
            state_d       = ST_WSST;
            warm_d        = 1'b1;
            ev_wdt_halt_o = 1'b1;
          end else if (wake_i) begin
            state_d = ST_WSST;
          end
        end
        ST_WSST: if (sst_done_i) begin
          state_d = ST_DUMMY;
          warm_d  = 1'b0;
        end
        ST_DUMMY: state_d = ST_RUN;
        default:  state_d = ST_SST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SST;
      halt_q  <= 1'b0;
      warm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_q  <= halt_i;
      warm_q  <= warm_d;
    end
  end

  assign state_o = state_q;
  assign warm_o  = warm_q;

  a_r7_dummy_from_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DUMMY) |-> $past(state_q) == ST_WSST);
  a_r10_wake_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !pin_act_i && !wdt_to_i && !halt_rise) |=> state_q == ST_RUN);
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic running_i,
  input  logic clr_i,
  input  logic ev_pin_halt_i,
  input  logic ev_wdt_run_i,
  input  logic ev_wdt_halt_i,
  input  logic ev_halt_i,
  output logic to_o,
  output logic pdf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_o  <= 1'b0;
      pdf_o <= 1'b0;
    end else if (ev_pin_halt_i) begin
      to_o  <= 1'b0;
      pdf_o <= 1'b1;
    end else if (ev_wdt_halt_i) begin
      to_o  <= 1'b1;
      pdf_o <= 1'b1;
    end else if (ev_wdt_run_i) begin
      to_o  <= 1'b1;
    end else if (ev_halt_i) begin
      to_o  <= 1'b0;
      pdf_o <= 1'b1;
    end else if (clr_i && running_i) begin
      to_o  <= 1'b0;
      pdf_o <= 1'b0;
    end
  end

  a_r3_wdt_halt_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wdt_halt_i |=> to_o && pdf_o);
  a_r2_wdt_run_pdf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wdt_run_i |=> to_o && pdf_o == $past(pdf_o));
  a_r8_halt_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_halt_i && !ev_pin_halt_i) |=> !to_o && pdf_o);
endmodule

// File: rtl/mcu_rst_seq.sv
module mcu_rst_seq
  import mcu_rst_pkg::*;
#(
  parameter int SST_W       = 10,
  parameter int OPT_CYCLES  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_rst_ni,
  input  logic wdt_timeout_i,
  input  logic wdt_clear_i,
  input  logic halt_i,
  input  logic wake_req_i,
  output logic cold_rst_o,
  output logic warm_rst_o,
  output logic core_hold_o,
  output logic dummy_o,
  output logic to_o,
  output logic pdf_o
);
  localparam int OPT_W = $clog2(OPT_CYCLES + 1);

  rst_state_e state;
  logic pin_act, sst_done, opt_done, warm;
  logic ev_pin_halt, ev_wdt_run, ev_wdt_halt, ev_halt;

  rst_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(pin_rst_ni), .active_o(pin_act));

  rst_delay_cnt #(.POW2(1'b1), .W(SST_W), .LIMIT(1)) u_sst (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(state == ST_SST || state == ST_WSST), .done_o(sst_done));

  rst_delay_cnt #(.POW2(1'b0), .W(OPT_W), .LIMIT(OPT_CYCLES)) u_opt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state == ST_OPT), .done_o(opt_done));

  rst_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_act_i(pin_act), .wdt_to_i(wdt_timeout_i),
    .halt_i(halt_i), .wake_i(wake_req_i), .sst_done_i(sst_done), .opt_done_i(opt_done),
    .state_o(state), .warm_o(warm), .ev_pin_halt_o(ev_pin_halt),
    .ev_wdt_run_o(ev_wdt_run), .ev_wdt_halt_o(ev_wdt_halt), .ev_halt_o(ev_halt));

  rst_cause_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .running_i(state == ST_RUN), .clr_i(wdt_clear_i),
    .ev_pin_halt_i(ev_pin_halt), .ev_wdt_run_i(ev_wdt_run), .ev_wdt_halt_i(ev_wdt_halt),
    .ev_halt_i(ev_halt), .to_o(to_o), .pdf_o(pdf_o));

  assign cold_rst_o  = (state == ST_PIN) || (state == ST_SST) || (state == ST_OPT);
  assign warm_rst_o  = (state == ST_WSST) && warm;
  assign core_hold_o = (state != ST_RUN) && (state != ST_HALT);
  assign dummy_o     = (state == ST_DUMMY);

  a_r3_warm_not_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> !cold_rst_o && core_hold_o);
  a_r1_cold_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_o |-> core_hold_o);
  a_r7_dummy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_o |=> !dummy_o && !core_hold_o);
  a_r4_pin_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act |=> cold_rst_o);
endmodule

// File: tb/mcu_rst_seq_bench.sv
module mcu_rst_seq_bench;
  localparam int SST = 1024;
  localparam int OPT = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, pin_rst_ni = 1'b1, wdt_timeout_i = 1'b0, wdt_clear_i = 1'b0;
  logic halt_i = 1'b0, wake_req_i = 1'b0;
  logic cold_rst_o, warm_rst_o, core_hold_o, dummy_o, to_o, pdf_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mcu_rst_seq u_mcu_rst_seq (
    .clk_i(clk), .rst_ni(rst_ni), .pin_rst_ni(pin_rst_ni), .wdt_timeout_i(wdt_timeout_i),
    .wdt_clear_i(wdt_clear_i), .halt_i(halt_i), .wake_req_i(wake_req_i),
    .cold_rst_o(cold_rst_o), .warm_rst_o(warm_rst_o), .core_hold_o(core_hold_o),
    .dummy_o(dummy_o), .to_o(to_o), .pdf_o(pdf_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // counts held samples starting at the current sample
  task automatic measure(output int n, output int nd, output int nw, output int nc,
                         output int dlast);
    n = 0; nd = 0; nw = 0; nc = 0; dlast = 0;
    while (core_hold_o && n < 4000) begin
      n++; nd += dummy_o; nw += warm_rst_o; nc += cold_rst_o; dlast = dummy_o;
      step();
    end
  endtask

  task automatic t_powerup();
    int n, nd, nw, nc, dl;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; #1;
    measure(n, nd, nw, nc, dl);
    chk("R1 hold cycles", n, SST + OPT);
    chk("R1 cold cycles", nc, SST + OPT);
    chk("R1 to", to_o, 0);
    chk("R1 pdf", pdf_o, 0);
  endtask

  task automatic t_glitch();
    int seen = 0;
    @(negedge clk) pin_rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    pin_rst_ni = 1'b1;
    repeat (12) begin step(); seen += cold_rst_o | core_hold_o; end
    chk("R6 glitch no reset", seen, 0);
    chk("R6 flags kept", {to_o, pdf_o}, 0);
  endtask

  task automatic t_wake_in_run();
    int seen = 0;
    @(negedge clk) wake_req_i = 1'b1;
    step(); wake_req_i = 1'b0;
    repeat (6) begin seen += core_hold_o | dummy_o; step(); end
    chk("R10 wake ignored in run", seen, 0);
  endtask

  task automatic t_halt(string tag);
    @(negedge clk) halt_i = 1'b1;
    step();
    chk({tag, " to after halt"}, to_o, 0);
    chk({tag, " pdf after halt"}, pdf_o, 1);
    chk({tag, " no hold in halt"}, core_hold_o, 0);
  endtask

  task automatic t_wake();
    int n, nd, nw, nc, dl;
    @(negedge clk) wake_req_i = 1'b1;
    step(); wake_req_i = 1'b0; halt_i = 1'b0;
    measure(n, nd, nw, nc, dl);
    chk("R7 hold cycles", n, SST + 1);
    chk("R7 dummy count", nd, 1);
    chk("R7 dummy last", dl, 1);
    chk("R7 no resets", nw + nc, 0);
    chk("R7 flags kept", {to_o, pdf_o}, 1);
  endtask

  task automatic t_wdt_run();
    int n, nd, nw, nc, dl;
    @(negedge clk) wdt_timeout_i = 1'b1;
    step(); wdt_timeout_i = 1'b0;
    measure(n, nd, nw, nc, dl);
    chk("R2 hold cycles", n, SST + OPT);
    chk("R2 cold cycles", nc, SST + OPT);
    chk("R2 to", to_o, 1);
    chk("R2 pdf kept", pdf_o, 1);
  endtask

  task automatic t_pin_run();
    int n, nd, nw, nc, dl;
    @(negedge clk) pin_rst_ni = 1'b0;
    repeat (20) step();
    chk("R4 cold during pin", cold_rst_o, 1);
    chk("R4 hold during pin", core_hold_o, 1);
    @(negedge clk) pin_rst_ni = 1'b1;
    #1 measure(n, nd, nw, nc, dl);
    chk("R4 delay after release", int'(n >= SST + OPT && n <= SST + OPT + 12), 1);
    chk("R4 flags kept", {to_o, pdf_o}, 3);
  endtask

  task automatic t_clear();
    @(negedge clk) wdt_clear_i = 1'b1;
    step(); wdt_clear_i = 1'b0;
    chk("R9 flags cleared", {to_o, pdf_o}, 0);
  endtask

  task automatic t_wdt_halt();
    int n, nd, nw, nc, dl;
    @(negedge clk) wdt_timeout_i = 1'b1;
    step(); wdt_timeout_i = 1'b0; halt_i = 1'b0;
    measure(n, nd, nw, nc, dl);
    chk("R3 hold cycles", n, SST + 1);
    chk("R3 warm cycles", nw, SST);
    chk("R3 no cold", nc, 0);
    chk("R3 dummy count", nd, 1);
    chk("R3 flags", {to_o, pdf_o}, 3);
  endtask

  task automatic t_pin_halt();
    int n, nd, nw, nc, dl;
    @(negedge clk) pin_rst_ni = 1'b0;
    repeat (20) step();
    halt_i = 1'b0;
    chk("R5 cold during pin", cold_rst_o, 1);
    @(negedge clk) pin_rst_ni = 1'b1;
    #1 measure(n, nd, nw, nc, dl);
    chk("R5 no warm", nw, 0);
    chk("R5 full delay", int'(n >= SST + OPT), 1);
    chk("R5 flags", {to_o, pdf_o}, 1);
  endtask

  initial begin
    t_powerup();
    t_glitch();
    t_wake_in_run();
    t_halt("R8");
    t_wake();
    t_wdt_run();
    t_pin_run();
    t_clear();
    t_halt("R8 second");
    t_wdt_halt();
    t_halt("R8 third");
    t_pin_halt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule